// File: doc/BRIEF.md
# Column Driver Pixel Demultiplexer

This block is the digital front end of one display column driver. A nine-lane data bus brings in one nine-bit half of a pixel per accepted beat, and two accepted halves form an 18-bit pixel that holds three 6-bit colour codes. Each pixel fills the next three columns of a register bank. The bank spans either 300 or 309 columns, and a mode pin picks which. Successive pixels after a line start go to successive column triples.

Several drivers can share one bus in sequence. A driver takes beats only while its enable-in is high. When its bank is full it raises its handoff output, which feeds the enable-in of the next driver, and it ignores the bus until the next line start. A load pulse copies the whole register bank into an output latch in one cycle. The latched 6-bit codes feed the column converters and stay steady while the next line is written into the registers.

Top module: `col_demux`

## Requirements
- R1: After reset, `cascOut` is 0 and every column code on `colCodes` is 0.
- R2: An accepted first beat supplies pixel bits 17..9 and the next accepted beat supplies bits 8..0. Bits 17..12 are red, 11..6 are green and 5..0 are blue.
- R3: The k-th pixel after a line start (k counted from 0) writes red to column 3k, green to column 3k+1 and blue to column 3k+2. Column c appears on `colCodes[6c+5:6c]` after a load.
- R4: With `wideMode`=1 the bank takes 103 pixels (309 columns). With `wideMode`=0 it takes 100 pixels (300 columns), and columns 300 to 308 are never written, so they keep their earlier contents.
- R5: `cascOut` goes to 1 on the clock edge that accepts the second beat of the last pixel of the bank. After that, beats are ignored until the next line start.
- R6: A beat that arrives while `cascIn` is 0 is ignored. It does not advance the half-pixel phase.
- R7: On a clock edge with `loadPulse` high, the latches take the register contents. A pixel counts as part of those contents if its second beat was accepted at least two edges earlier. At every other edge, `colCodes` holds its value, even while new pixels are being written.
- R8: `lineStart` returns the pointer to pixel 0 and the phase to the first half, and clears `cascOut` on the same edge. A beat offered in the same cycle as `lineStart` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one beat per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| wideMode | input | 1 | 1 selects the 309-column bank, 0 selects the 300-column bank |
| lineStart | input | 1 | Line start strobe |
| cascIn | input | 1 | Enable-in from the previous driver (tie high on the first driver) |
| beatValid | input | 1 | A beat is present on `beatData` |
| beatData | input | 9 | Nine-lane half pixel |
| loadPulse | input | 1 | Copies the register bank into the output latch |
| cascOut | output | 1 | Bank full; enable-in for the next driver |
| colCodes | output | 1854 | Latched 6-bit codes, column c at bits 6c+5..6c |

## Verification
A wrong pointer or phase shows up as whole colour codes landing in the wrong column triple, or with halves swapped. That appears in the first latch snapshot after a load. A wrong full count moves the edge where `cascOut` rises by at least one pixel, which is two cycles, so the bench checks that flag one pixel before and exactly at the bank boundary. A latch that loads when it should not changes `colCodes` while the next line is written, and that is caught within the same line.

// File: rtl/cdmux_pkg.sv
package cdmux_pkg;
  localparam int LANES      = 9;
  localparam int CODE_W     = 6;
  localparam int COLOURS    = 3;
  localparam int NARROW_COL = 300;
  localparam int WIDE_COL   = 309;
  localparam int PIX_W      = 2 * LANES;
  localparam int PIX_WIDE   = WIDE_COL / COLOURS;
  localparam int PIX_NARROW = NARROW_COL / COLOURS;
  localparam int IDX_W      = $clog2(PIX_WIDE + 1);

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] pixIdx;
    logic [PIX_W-1:0] pix;
    logic             load;
  } ctlStrobe_t;
endpackage

// File: rtl/cdmux_ctrl.sv
module cdmux_ctrl
  import cdmux_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wideMode,
  input  logic             lineStart,
  input  logic             cascIn,
  input  logic             beatValid,
  input  logic [LANES-1:0] beatData,
  input  logic             loadPulse,
  output logic             cascOut,
  output ctlStrobe_t       strb
);
  logic             phase;
  logic [LANES-1:0] hiHalf;
  logic [IDX_W-1:0] ptr;
  logic             full;
  logic             wrEnQ;
  logic [IDX_W-1:0] idxQ;
  logic [PIX_W-1:0] pixQ;
  logic [IDX_W-1:0] limit;
  logic             accept;

  assign limit  = wideMode ? IDX_W'(PIX_WIDE) : IDX_W'(PIX_NARROW);
  assign accept = beatValid && cascIn && !full;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= 1'b0;
      hiHalf <= '0;
      ptr    <= '0;
      full   <= 1'b0;
      wrEnQ  <= 1'b0;
      idxQ   <= '0;
      pixQ   <= '0;
    end else if (lineStart) begin
      phase <= 1'b0;
      ptr   <= '0;
      full  <= 1'b0;
      wrEnQ <= 1'b0;
    end else begin
      wrEnQ <= 1'b0;
      if (accept) begin
        if (!phase) begin
          hiHalf <= beatData;
          phase  <= 1'b1;
        end else begin
          phase <= 1'b0;
          pixQ  <= {hiHalf, beatData};
          idxQ  <= ptr;
          wrEnQ <= 1'b1;
          ptr   <= ptr + 1'b1;
          if (ptr + 1'b1 == limit) full <= 1'b1;
        end
      end
    end
  end

  assign cascOut = full;

  always_comb begin
    strb.wrEn   = wrEnQ;
    strb.pixIdx = idxQ;
    strb.pix    = pixQ;
    strb.load   = loadPulse;
  end

  // R4: the pixel pointer never passes the bank size
  p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= limit);
  // R5: a full bank produces no further writes until a line start
  p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (full && !lineStart) |=> !wrEnQ);
  // R6: every write comes from a beat taken while enabled
  p_gate_cascin_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEnQ |-> $past(cascIn));
  // R8: line start clears the handoff and the pointer
  p_linestart_r8: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> (!cascOut && ptr == '0 && !phase));
endmodule

// File: rtl/cdmux_bank.sv
module cdmux_bank
  import cdmux_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wideMode,
  input  ctlStrobe_t                   strb,
  output logic [WIDE_COL*CODE_W-1:0]   colCodes
);
  for (genvar p = 0; p < PIX_WIDE; p++) begin : g_pix
    logic [CODE_W-1:0] regC [COLOURS];
    logic [CODE_W-1:0] latC [COLOURS];
    logic              hit;
    assign hit = strb.wrEn && (strb.pixIdx == IDX_W'(p));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int c = 0; c < COLOURS; c++) begin
          regC[c] <= '0;
          latC[c] <= '0;
        end
      end else begin
        for (int c = 0; c < COLOURS; c++) begin
          if (hit) regC[c] <= strb.pix[PIX_W-1-c*CODE_W -: CODE_W];
          if (strb.load) latC[c] <= regC[c];
        end
      end
    end

    for (genvar c = 0; c < COLOURS; c++) begin : g_col
      assign colCodes[(p*COLOURS+c)*CODE_W +: CODE_W] = latC[c];
    end
  end

  // R7: outside a load the latched codes do not move
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(colCodes));
  // R4: the narrow bank never writes past pixel 99
  p_narrow_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !wideMode) |-> (strb.pixIdx < IDX_W'(PIX_NARROW)));
endmodule

// File: rtl/col_demux.sv
module col_demux
  import cdmux_pkg::*;
#(
  parameter int LANES_P = LANES,
  parameter int COLS_P  = WIDE_COL,
  parameter int CODE_P  = CODE_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wideMode,
  input  logic                      lineStart,
  input  logic                      cascIn,
  input  logic                      beatValid,
  input  logic [LANES_P-1:0]        beatData,
  input  logic                      loadPulse,
  output logic                      cascOut,
  output logic [COLS_P*CODE_P-1:0]  colCodes
);
  ctlStrobe_t strb;

  cdmux_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .lineStart(lineStart),
    .cascIn(cascIn), .beatValid(beatValid), .beatData(beatData),
    .loadPulse(loadPulse), .cascOut(cascOut), .strb(strb)
  );

  cdmux_bank i_bank (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .strb(strb),
    .colCodes(colCodes)
  );
endmodule

// File: tb/test_col_demux.sv
module test_col_demux;
  localparam int NCOL = 309;
  localparam int FW   = NCOL * 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wideMode = 1'b0, lineStart = 1'b0, cascIn = 1'b1;
  logic beatValid = 1'b0, loadPulse = 1'b0, loadD = 1'b0;
  logic [8:0] beatData = '0;
  logic cascOut;
  logic [FW-1:0] colCodes;

  col_demux i_col_demux (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .lineStart(lineStart),
    .cascIn(cascIn), .beatValid(beatValid), .beatData(beatData),
    .loadPulse(loadPulse), .cascOut(cascOut), .colCodes(colCodes)
  );

  always #2 clk = ~clk;

  int nChk = 0, nFail = 0;
  logic [5:0] mReg [NCOL];
  logic       mPhase = 1'b0, mFull = 1'b0;
  int         mPtr = 0;
  logic [8:0] mHi = '0;
  logic [FW-1:0] expQ [$];
  logic [FW-1:0] lastSnap = '0;

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] snap();
    logic [FW-1:0] v;
    for (int c = 0; c < NCOL; c++) v[c*6 +: 6] = mReg[c];
    return v;
  endfunction

  task automatic compareFrame(input logic [FW-1:0] exp, input string req);
    int bad = -1;
    for (int c = NCOL - 1; c >= 0; c--)
      if (colCodes[c*6 +: 6] !== exp[c*6 +: 6]) bad = c;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, $sformatf("%s col %0d", req, bad),
               colCodes[bad*6 +: 6], exp[bad*6 +: 6]);
  endtask

  // driver: one beat, inputs changed at negedge
  task automatic beat(input logic [8:0] d, input logic cin);
    beatValid = 1'b1; beatData = d; cascIn = cin;
    @(negedge clk);
    beatValid = 1'b0; cascIn = 1'b1;
    if (cin && !mFull) begin
      if (!mPhase) begin mHi = d; mPhase = 1'b1; end
      else begin
        mPhase = 1'b0;
        mReg[3*mPtr]   = mHi[8:3];
        mReg[3*mPtr+1] = {mHi[2:0], d[8:6]};
        mReg[3*mPtr+2] = d[5:0];
        mPtr++;
        if (mPtr == (wideMode ? 103 : 100)) mFull = 1'b1;
      end
    end
  endtask

  task automatic pixel(input int k);
    logic [17:0] p;
    p = {6'((k*7 + 1) & 63), 6'((k*13 + 5) & 63), 6'((k*29 + 11) & 63)};
    beat(p[17:9], 1'b1);
    beat(p[8:0], 1'b1);
  endtask

  task automatic startLine(input logic wide, input logic withBeat);
    wideMode = wide; lineStart = 1'b1;
    beatValid = withBeat; beatData = 9'h1a5;
    @(negedge clk);
    lineStart = 1'b0; beatValid = 1'b0;
    mPtr = 0; mPhase = 1'b0; mFull = 1'b0;
    check(cascOut == 1'b0, "R8 cascOut cleared", cascOut, 0);
  endtask

  task automatic doLoad();
    @(negedge clk);
    expQ.push_back(snap());
    loadPulse = 1'b1;
    @(negedge clk);
    loadPulse = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compare the latch against the queued expectation after each load
  always @(posedge clk) loadD <= loadPulse;
  always @(negedge clk) begin
    if (loadD && expQ.size() > 0) begin
      lastSnap = expQ.pop_front();
      compareFrame(lastSnap, "R2 R3 R7 snapshot");
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCOL; c++) mReg[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cascOut == 1'b0, "R1 cascOut", cascOut, 0);
    check(colCodes == '0, "R1 codes zero", 0, 0);

    // narrow line, boundary of the 300-column bank
    startLine(1'b0, 1'b0);
    for (int k = 0; k < 99; k++) pixel(k);
    check(cascOut == 1'b0, "R5 not full at 99", cascOut, 0);
    pixel(99);
    check(cascOut == 1'b1, "R4 R5 full at 100", cascOut, 1);
    for (int k = 100; k < 103; k++) pixel(k);   // ignored after full (R5)
    check(cascOut == 1'b1, "R5 stays full", cascOut, 1);
    doLoad();

    // wide line; the latch must hold while the registers change
    startLine(1'b1, 1'b0);
    for (int k = 200; k < 210; k++) pixel(k);
    compareFrame(lastSnap, "R7 latch hold");
    // enable-in low between halves is ignored (R6)
    beat(9'h0f3, 1'b1);
    beat(9'h1ff, 1'b0);
    beat(9'h155, 1'b0);
    beat(9'h02c, 1'b1);
    for (int k = 0; k < 5; k++) beat(9'(k * 37), 1'b0);
    for (int k = 211; k < 302; k++) pixel(k);
    check(cascOut == 1'b0, "R4 wide not full at 102", cascOut, 0);
    pixel(302);
    check(cascOut == 1'b1, "R4 wide full at 103", cascOut, 1);
    doLoad();

    // line start during a half pixel and with a beat in the same cycle
    startLine(1'b1, 1'b0);
    beat(9'h111, 1'b1);
    startLine(1'b1, 1'b1);
    for (int k = 400; k < 404; k++) pixel(k);
    check(cascOut == 1'b0, "R8 not full after restart", cascOut, 0);
    doLoad();

    // narrow line leaves columns 300-308 untouched (R4)
    startLine(1'b0, 1'b0);
    for (int k = 500; k < 600; k++) pixel(k);
    check(cascOut == 1'b1, "R4 narrow full again", cascOut, 1);
    doLoad();
    check(expQ.size() == 0, "R7 all loads observed", expQ.size(), 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule